// File: doc/BRIEF.md
# Four-Lane AES-128 Counter-Mode Keystream Engine

This block turns wide data words into ciphertext, or back into plaintext, by counter-mode keystream mixing. Every accepted word is split into 128-bit lanes. The block encrypts a distinct counter value for each lane under an AES-128 key and XORs that encrypted value into the lane. The cipher only ever sees counter values and never the data. Because of this, the same operation with the same key and starting counter undoes itself, and one circuit serves both directions.

A seeding strobe captures the key and the starting counter. After that, each word consumes one counter value per lane, and the counter base moves past all of them so that no counter block is encrypted twice. A single iterative round engine serves the lanes one after another, completing one cipher round per clock cycle. The key schedule is derived on the fly, round by round, next to the data path. The result leaves through a register with a one-cycle valid pulse.

Top module: `aes_ctr4_core`

## Requirements
- R1: For an accepted word, output lane i (bits [128*i+127:128*i], lane 0 in the lowest bits) equals input lane i XOR AES-128(key, base + i), where base is the counter base at acceptance.
- R2: The cipher is standard AES-128 with big-endian byte order (byte 0 in bits [127:120]). With key 000102030405060708090a0b0c0d0e0f, counter 00112233445566778899aabbccddeeff and an all-zero lane 0, lane 0 of the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: Counter values are 128-bit unsigned integers incremented modulo 2^128, so lanes whose counter passes ff..ff wrap to 0, 1, and so on.
- R4: After each completed word the counter base advances by LANES (4). A seed strobe (seed_load high while idle) loads the key from seed_key and the base from seed_ctr.
- R5: Applying the block a second time, with the same key and starting counter, to its own output returns the original data.
- R6: in_ready is high only while idle with seed_load low. A word offered while busy is not accepted and does not move the counter base.
- R7: seed_load while a word is in progress is ignored: neither the key nor the base changes.
- R8: out_valid is a single-cycle pulse raised LANES*10 (40) rising edges after the accepting edge. out_data holds its value after the pulse until the next word is processed.
- R9: After reset, out_valid is low, in_ready is high, and key and counter base are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_load | input | 1 | Captures seed_key and seed_ctr when idle |
| seed_key | input | 128 | AES-128 key to capture |
| seed_ctr | input | 128 | Starting counter value to capture |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 512 | Data word, lane 0 in bits [127:0] |
| out_valid | output | 1 | One-cycle pulse: out_data is complete |
| out_data | output | 512 | Keystream-mixed result |

## Verification
The bench builds the block with its default of four lanes, so each word spans 512 bits and takes 40 cycles. At that width a starting counter two below the top of the 128-bit range pushes lanes 2 and 3 through the wrap. Back-to-back words under one seed show the base stepping by four. A known single-block vector anchors the cipher's byte order, and a second pass over the output confirms that decryption is the same operation.

// File: rtl/aes_ctr4_pkg.sv
package aes_ctr4_pkg;

    localparam int BLK_W  = 128;
    localparam int NROUND = 10;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [7:0]       byte_t;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_x2(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = 8'h00;
        byte_t t   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_x2(t);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse (0 maps to 0)
    function automatic byte_t gf_inv(byte_t a);
        byte_t p = a;
        byte_t r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t sbox(byte_t x);
        byte_t y = gf_inv(x);
        byte_t s;
        for (int i = 0; i < 8; i++)
            s[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8];
        return s ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_ctr4_keystep.sv
module aes_ctr4_keystep
    import aes_ctr4_pkg::*;
(
    input  blk_t  rk_i,
    input  byte_t rcon_i,
    output blk_t  rk_o
);
    logic [31:0] last_w;
    logic [31:0] rot_w;
    logic [31:0] sub_w;
    logic [31:0] mix_w;
    logic [31:0] w0_n, w1_n, w2_n, w3_n;

    assign last_w = rk_i[31:0];
    assign rot_w  = {last_w[23:0], last_w[31:24]};

    for (genvar g = 0; g < 4; g++) begin : g_sub
        assign sub_w[8*g +: 8] = sbox(rot_w[8*g +: 8]);
    end

    assign mix_w = sub_w ^ {rcon_i, 24'h000000};
    assign w0_n  = rk_i[127:96] ^ mix_w;
    assign w1_n  = rk_i[95:64]  ^ w0_n;
    assign w2_n  = rk_i[63:32]  ^ w1_n;
    assign w3_n  = rk_i[31:0]   ^ w2_n;
    assign rk_o  = {w0_n, w1_n, w2_n, w3_n};

endmodule

// File: rtl/aes_ctr4_round.sv
module aes_ctr4_round
    import aes_ctr4_pkg::*;
(
    input  blk_t blk_i,
    input  blk_t rk_i,
    input  logic last_i,
    output blk_t blk_o
);
    byte_t sub_b [16];
    byte_t shf_b [16];
    byte_t mix_b [16];

    for (genvar g = 0; g < 16; g++) begin : g_sbox
        assign sub_b[g] = sbox(blk_i[127-8*g -: 8]);
    end

    // byte index 4*col+row; row r rotates left by r columns
    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign shf_b[4*c+r] = sub_b[4*((c+r)%4)+r];
        end
        assign mix_b[4*c+0] = gf_x2(shf_b[4*c]) ^ gf_x2(shf_b[4*c+1]) ^ shf_b[4*c+1]
                            ^ shf_b[4*c+2] ^ shf_b[4*c+3];
        assign mix_b[4*c+1] = shf_b[4*c] ^ gf_x2(shf_b[4*c+1]) ^ gf_x2(shf_b[4*c+2])
                            ^ shf_b[4*c+2] ^ shf_b[4*c+3];
        assign mix_b[4*c+2] = shf_b[4*c] ^ shf_b[4*c+1] ^ gf_x2(shf_b[4*c+2])
                            ^ gf_x2(shf_b[4*c+3]) ^ shf_b[4*c+3];
        assign mix_b[4*c+3] = gf_x2(shf_b[4*c]) ^ shf_b[4*c] ^ shf_b[4*c+1]
                            ^ shf_b[4*c+2] ^ gf_x2(shf_b[4*c+3]);
    end

    for (genvar g = 0; g < 16; g++) begin : g_key
        assign blk_o[127-8*g -: 8] = (last_i ? shf_b[g] : mix_b[g]) ^ rk_i[127-8*g -: 8];
    end

endmodule

// File: rtl/aes_ctr4_core.sv
module aes_ctr4_core
    import aes_ctr4_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seed_load,
    input  logic [127:0]           seed_key,
    input  logic [127:0]           seed_ctr,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*128-1:0]   in_data,
    output logic                   out_valid,
    output logic [LANES*128-1:0]   out_data
);
    localparam int DW = LANES * BLK_W;
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);
    localparam logic [3:0]    LAST_RND  = 4'(NROUND);

    typedef struct packed {
        logic          busy;
        logic          vld;
        logic [LW-1:0] lane;
        logic [3:0]    rnd;
        byte_t         rcon;
        blk_t          blk;
        blk_t          rk;
        blk_t          key;
        blk_t          base;
        logic [DW-1:0] data;
        logic [DW-1:0] res;
    } st_t;

    st_t  st_d, st_q;
    blk_t rk_nx;
    blk_t blk_nx;

    aes_ctr4_keystep u_key (
        .rk_i   (st_q.rk),
        .rcon_i (st_q.rcon),
        .rk_o   (rk_nx)
    );

    aes_ctr4_round u_round (
        .blk_i  (st_q.blk),
        .rk_i   (rk_nx),
        .last_i (st_q.rnd == LAST_RND),
        .blk_o  (blk_nx)
    );

    assign in_ready  = !st_q.busy && !seed_load;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.res;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!st_q.busy) begin
            if (seed_load) begin
                st_d.key  = seed_key;
                st_d.base = seed_ctr;
            end else if (in_valid) begin
                st_d.busy = 1'b1;
                st_d.data = in_data;
                st_d.lane = '0;
                st_d.rnd  = 4'd1;
                st_d.rcon = 8'h01;
                st_d.blk  = st_q.base ^ st_q.key;
                st_d.rk   = st_q.key;
            end
        end else if (st_q.rnd == LAST_RND) begin
            st_d.res[st_q.lane*BLK_W +: BLK_W] = blk_nx ^ st_q.data[st_q.lane*BLK_W +: BLK_W];
            if (st_q.lane == LAST_LANE) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
                st_d.base = st_q.base + 128'(LANES);
            end else begin
                st_d.lane = st_q.lane + 1'b1;
                st_d.rnd  = 4'd1;
                st_d.rcon = 8'h01;
                st_d.blk  = (st_q.base + 128'(st_q.lane) + 128'd1) ^ st_q.key;
                st_d.rk   = st_q.key;
            end
        end else begin
            st_d.rnd  = st_q.rnd + 4'd1;
            st_d.rcon = gf_x2(st_q.rcon);
            st_d.blk  = blk_nx;
            st_d.rk   = rk_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: no acceptance window while a word is in progress
    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !in_ready);

    // R8: an accepted word starts processing on the next cycle
    a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> st_q.busy);

    // R8: valid never lasts beyond one cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: each completed word moves the base by the lane count
    a_r4_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> st_q.base == $past(st_q.base) + 128'(LANES));

    // R7: key is frozen while busy, whatever seed_load does
    a_r7_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.key));

    // R8: round counter stays inside the cipher's round range while busy
    a_r8_round_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.rnd >= 4'd1 && st_q.rnd <= LAST_RND));

endmodule

// File: tb/aes_ctr4_core_test.sv
`timescale 1ns/1ps
module aes_ctr4_core_test;

    localparam int LANES = 4;
    localparam int DW    = LANES * 128;
    localparam int LAT   = LANES * 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seed_load = 1'b0;
    logic [127:0]  seed_key = '0;
    logic [127:0]  seed_ctr = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] sb [256];

    always #10 clk = ~clk;

    aes_ctr4_core #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_key(seed_key),
        .seed_ctr(seed_ctr), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    localparam logic [127:0] T_KEY [3] = '{
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'h000102030405060708090a0b0c0d0e0f,
        128'hffffffffffffffffffffffffffffffff };
    localparam logic [127:0] T_CTR [3] = '{
        128'hf0f1f2f3f4f5f6f7f8f9fafbfcfdfeff,
        128'h00000000000000000000000000000001,
        128'h0123456789abcdef0011223344556677 };
    localparam logic [511:0] T_DAT [3] = '{
        512'h6bc1bee22e409f96e93d7e117393172aae2d8a571e03ac9c9eb76fac45af8e5130c81c46a35ce411e5fbc1191a0a52eff69f2445df4f9b17ad2b417be66c3710,
        {16{32'h5a5aa5a5}},
        512'h0 };

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl8(logic [7:0] v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [127:0] ref_aes(logic [127:0] k, logic [127:0] p);
        logic [31:0] w [44];
        logic [31:0] tmp;
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [7:0]  rc = 8'h01;
        logic [127:0] o;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = ref_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int q = 0; q < 4; q++) s[4*c+q] = t[4*((c+q)%4)+q];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    for (int q = 0; q < 4; q++) t[q] = s[4*c+q];
                    s[4*c+0] = ref_mul(t[0],8'h02) ^ ref_mul(t[1],8'h03) ^ t[2] ^ t[3];
                    s[4*c+1] = t[0] ^ ref_mul(t[1],8'h02) ^ ref_mul(t[2],8'h03) ^ t[3];
                    s[4*c+2] = t[0] ^ t[1] ^ ref_mul(t[2],8'h02) ^ ref_mul(t[3],8'h03);
                    s[4*c+3] = ref_mul(t[0],8'h03) ^ t[1] ^ t[2] ^ ref_mul(t[3],8'h02);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*r + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    function automatic logic [DW-1:0] model_word(logic [127:0] k, logic [127:0] c, logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[128*i +: 128] = d[128*i +: 128] ^ ref_aes(k, c + 128'(i));
        return r;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_seed(input logic [127:0] k, input logic [127:0] c);
        @(negedge clk);
        seed_load = 1'b1; seed_key = k; seed_ctr = c;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    // leaves the bench one cycle after the valid pulse
    task automatic run_word(input logic [DW-1:0] d, output logic [DW-1:0] res,
                            output int lat, output logic pulse_ok);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(posedge clk); @(negedge clk); lat++;
        end
        res = out_data;
        @(posedge clk); @(negedge clk);
        pulse_ok = !out_valid && (out_data === res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] res, res2, ct;
        int lat;
        logic pok;
        logic [127:0] k_a, c_a;

        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (ref_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sb[x] = inv ^ rotl8(inv,1) ^ rotl8(inv,2) ^ rotl8(inv,3) ^ rotl8(inv,4) ^ 8'h63;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 out_valid after reset", DW'(out_valid), DW'(1'b0));
        chk("R9 in_ready after reset", DW'(in_ready), DW'(1'b1));
        // R9: zero key and zero base without seeding
        run_word(T_DAT[0], res, lat, pok);
        chk("R9 zero key/base word", res, model_word('0, '0, T_DAT[0]));

        // R2: known single-block vector in lane 0
        do_seed(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff);
        run_word('0, res, lat, pok);
        chk("R2 known vector lane 0", DW'(res[127:0]), DW'(128'h69c4e0d86a7b0430d8cdb78070b4c55a));

        // table walk: R1 lanes, R8 latency and pulse, R4 base step
        for (int v = 0; v < 3; v++) begin
            do_seed(T_KEY[v], T_CTR[v]);
            run_word(T_DAT[v], res, lat, pok);
            chk("R1 lane keystream", res, model_word(T_KEY[v], T_CTR[v], T_DAT[v]));
            chk("R8 latency", DW'(lat), DW'(LAT));
            chk("R8 single pulse and hold", DW'(pok), DW'(1'b1));
            run_word(T_DAT[v], res2, lat, pok);
            chk("R4 base advanced by four", res2, model_word(T_KEY[v], T_CTR[v] + 128'd4, T_DAT[v]));
        end

        // R3: counter wrap inside one word
        do_seed(T_KEY[0], 128'hfffffffffffffffffffffffffffffffe);
        run_word(T_DAT[0], res, lat, pok);
        chk("R3 counter wrap", res, model_word(T_KEY[0], 128'hfffffffffffffffffffffffffffffffe, T_DAT[0]));
        chk("R3 wrapped lane 2 uses counter 0", DW'(res[383:256]),
            DW'(T_DAT[0][383:256] ^ ref_aes(T_KEY[0], 128'h0)));

        // R5: second pass restores the data
        do_seed(T_KEY[2], T_CTR[0]);
        run_word(T_DAT[0], ct, lat, pok);
        do_seed(T_KEY[2], T_CTR[0]);
        run_word(ct, res, lat, pok);
        chk("R5 decrypt round trip", res, T_DAT[0]);

        // R6 and R7: offers and seeds while busy are ignored
        k_a = T_KEY[1]; c_a = 128'h00000000000000000000000000000100;
        do_seed(k_a, c_a);
        @(negedge clk);
        in_valid = 1'b1; in_data = T_DAT[0];
        @(posedge clk);
        @(negedge clk);
        in_data = T_DAT[1];
        chk("R6 in_ready low while busy", DW'(in_ready), DW'(1'b0));
        repeat (5) @(negedge clk);
        seed_load = 1'b1; seed_key = T_KEY[2]; seed_ctr = 128'h77;
        @(negedge clk);
        seed_load = 1'b0;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(posedge clk); @(negedge clk); lat++;
        end
        chk("R7 seed ignored while busy", out_data, model_word(k_a, c_a, T_DAT[0]));
        run_word(T_DAT[2], res, lat, pok);
        chk("R6 busy offer not accepted", res, model_word(k_a, c_a + 128'd4, T_DAT[2]));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule